// File: doc/BRIEF.md
# Per-Key Edge Interrupt Controller

This block watches a 64-bit vector of already debounced key states and turns state changes into interrupt events. Each key has its own 2-bit edge selector that picks rising edges, falling edges, both edges or no edges. A detected edge sets that key's pending bit, and a 64-bit enable mask picks which pending bits drive the single level interrupt output.

Software programs the block through a simple 32-bit register port with a write strobe and a combinational read. The port gives access to a configuration word (bit 0 gates event capture), four edge-selector words, two mask words, two write-one-to-clear words, two pending-status words and two words that mirror the raw key state. Key number `8*row + col` is used throughout, so each byte of a mask, clear or pending word is one row of the key matrix.

Top module: `key_edge_irq`

## Requirements
- R1: After reset, the pending words (0xC0, 0xC4), mask words (0xB0, 0xB4), edge-selector words (0x90–0x9C) and configuration word (0x80) read 0, and `irq` is low.
- R2: Edge-selector word at 0x90+4k sets the mode of key 16k+i in bits 2i+1:2i. Mode 0 captures no edge, 1 captures rising edges only, 2 captures falling edges only and 3 captures both.
- R3: Key number is 8*row + col. Word 0xB0 bit b enables key b (rows 0–3), and word 0xB4 bit b enables key 32+b (rows 4–7). The pending and clear words use the same layout.
- R4: A pending bit is set only while configuration bit 0 is 1. With the bit at 0, key edges leave the pending words unchanged.
- R5: Writing to 0xB8 (keys 0–31) or 0xBC (keys 32–63) clears each pending bit whose data bit is 1 and leaves bits written with 0 unchanged. A write of all ones empties that half.
- R6: If a clear write and a captured edge hit the same key on the same clock edge, the edge wins and the bit stays pending. Other bits in the same clear write are still cleared.
- R7: `irq` is high exactly when some key is both pending and enabled. A pending bit whose enable is 0 stays readable but does not raise `irq`.
- R8: Pending bits read at 0xC0 (keys 0–31) and 0xC4 (keys 32–63). Writes to these two addresses have no effect.
- R9: Words 0xA0 and 0xA4 return the current key state of keys 0–31 and 32–63.
- R10: The configuration, edge-selector and mask words read back the last value written.
- R11: A key change applied between clock edges is sampled at the next rising edge. Pending and `irq` reflect it right after that edge and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| keyState | input | 64 | Debounced key states, key 8*row+col |
| wrEn | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address |
| wrData | input | 32 | Register write data |
| rdData | output | 32 | Combinational read data for `addr` |
| irq | output | 1 | Level interrupt, OR of pending AND mask |

## Verification
A captured key edge and a software clear can land on the same key in the same cycle. The bench provokes this by raising a key and issuing a clear write that covers that key and a second pending key in the same half cycle before one rising edge. It then expects the key with the fresh edge to stay pending and the other key to be cleared. Checks made just before and just after the sampling edge pin the one-cycle latency from a key change to pending and `irq`.

// File: rtl/keyirq_pkg.sv
package keyirq_pkg;
  localparam int KEY_COUNT  = 64;
  localparam int REG_W      = 32;
  localparam int MODE_BITS  = 2;
  localparam int MODE_REGS  = KEY_COUNT * MODE_BITS / REG_W;
  localparam int HALF_REGS  = KEY_COUNT / REG_W;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_CFG,
    RD_MODE,
    RD_STATUS,
    RD_MASK,
    RD_PEND
  } rdSel_e;

  typedef struct packed {
    logic                 cfgWr;
    logic [MODE_REGS-1:0] modeWr;
    logic [HALF_REGS-1:0] maskWr;
    logic [HALF_REGS-1:0] clrWr;
    rdSel_e               rdSel;
    logic [1:0]           rdIdx;
  } regStrobe_t;
endpackage

// File: rtl/keyirq_edge_cell.sv
module keyirq_edge_cell (
  input  logic       prevBit,
  input  logic       curBit,
  input  logic [1:0] mode,
  output logic       hit
);
  // mode[0] selects rising, mode[1] selects falling
  assign hit = (mode[0] & ~prevBit & curBit) | (mode[1] & prevBit & ~curBit);
endmodule

// File: rtl/keyirq_ctrl.sv
module keyirq_ctrl
  import keyirq_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int OFF_CFG  = 'h80,
  parameter int OFF_MODE = 'h90,
  parameter int OFF_STAT = 'hA0,
  parameter int OFF_MASK = 'hB0,
  parameter int OFF_CLR  = 'hB8,
  parameter int OFF_PEND = 'hC0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output regStrobe_t        strobe
);
  always_comb begin
    strobe        = '0;
    strobe.rdSel  = RD_ZERO;
    strobe.cfgWr  = wrEn && (addr == ADDR_W'(OFF_CFG));
    if (addr == ADDR_W'(OFF_CFG)) strobe.rdSel = RD_CFG;
    for (int k = 0; k < MODE_REGS; k++) begin
      if (addr == ADDR_W'(OFF_MODE + 4 * k)) begin
        strobe.modeWr[k] = wrEn;
        strobe.rdSel     = RD_MODE;
        strobe.rdIdx     = 2'(k);
      end
    end
    for (int h = 0; h < HALF_REGS; h++) begin
      if (addr == ADDR_W'(OFF_STAT + 4 * h)) begin
        strobe.rdSel = RD_STATUS;
        strobe.rdIdx = 2'(h);
      end
      if (addr == ADDR_W'(OFF_MASK + 4 * h)) begin
        strobe.maskWr[h] = wrEn;
        strobe.rdSel     = RD_MASK;
        strobe.rdIdx     = 2'(h);
      end
      if (addr == ADDR_W'(OFF_CLR + 4 * h)) begin
        strobe.clrWr[h] = wrEn;
      end
      if (addr == ADDR_W'(OFF_PEND + 4 * h)) begin
        strobe.rdSel = RD_PEND;
        strobe.rdIdx = 2'(h);
      end
    end
  end

  // R10: a write reaches at most one register
  a_r10_single_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.cfgWr, strobe.modeWr, strobe.maskWr, strobe.clrWr}));
endmodule

// File: rtl/keyirq_datapath.sv
module keyirq_datapath
  import keyirq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [KEY_COUNT-1:0] keyState,
  input  logic [REG_W-1:0]     wrData,
  input  regStrobe_t           strobe,
  output logic [REG_W-1:0]     rdData,
  output logic                 irq
);
  logic [REG_W-1:0]     cfgQ;
  logic [REG_W-1:0]     modeQ [MODE_REGS];
  logic [KEY_COUNT-1:0] maskQ;
  logic [KEY_COUNT-1:0] pendQ;
  logic [KEY_COUNT-1:0] prevQ;
  logic [KEY_COUNT*MODE_BITS-1:0] modeFlat;
  logic [KEY_COUNT-1:0] hitVec;
  logic [KEY_COUNT-1:0] qualEvt;
  logic [KEY_COUNT-1:0] clrVec;
  logic                 capEn;

  assign capEn = cfgQ[0];

  genvar g;
  generate
    for (g = 0; g < MODE_REGS; g++) begin : g_flat
      assign modeFlat[g*REG_W +: REG_W] = modeQ[g];
    end
    for (g = 0; g < HALF_REGS; g++) begin : g_clr
      assign clrVec[g*REG_W +: REG_W] = strobe.clrWr[g] ? wrData : '0;
    end
    for (g = 0; g < KEY_COUNT; g++) begin : g_key
      keyirq_edge_cell i_cell (
        .prevBit (prevQ[g]),
        .curBit  (keyState[g]),
        .mode    (modeFlat[g*MODE_BITS +: MODE_BITS]),
        .hit     (hitVec[g])
      );
    end
  endgenerate

  assign qualEvt = hitVec & {KEY_COUNT{capEn}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ  <= '0;
      maskQ <= '0;
      pendQ <= '0;
      prevQ <= '0;
      for (int k = 0; k < MODE_REGS; k++) modeQ[k] <= '0;
    end else begin
      prevQ <= keyState;
      pendQ <= (pendQ & ~clrVec) | qualEvt;
      if (strobe.cfgWr) cfgQ <= wrData;
      for (int k = 0; k < MODE_REGS; k++)
        if (strobe.modeWr[k]) modeQ[k] <= wrData;
      for (int h = 0; h < HALF_REGS; h++)
        if (strobe.maskWr[h]) maskQ[h*REG_W +: REG_W] <= wrData;
    end
  end

  always_comb begin
    case (strobe.rdSel)
      RD_CFG:    rdData = cfgQ;
      RD_MODE:   rdData = modeQ[strobe.rdIdx];
      RD_STATUS: rdData = keyState[strobe.rdIdx[0]*REG_W +: REG_W];
      RD_MASK:   rdData = maskQ[strobe.rdIdx[0]*REG_W +: REG_W];
      RD_PEND:   rdData = pendQ[strobe.rdIdx[0]*REG_W +: REG_W];
      default:   rdData = '0;
    endcase
  end

  assign irq = |(pendQ & maskQ);

  a_r4_no_capture_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !capEn |=> ((pendQ & ~$past(pendQ)) == '0));

  a_r5_clear_takes_effect: assert property (@(posedge clk) disable iff (!rstN)
    (|clrVec) |=> ((pendQ & $past(clrVec & ~qualEvt)) == '0));

  a_r6_edge_beats_clear: assert property (@(posedge clk) disable iff (!rstN)
    (|(clrVec & qualEvt)) |=> ((~pendQ & $past(clrVec & qualEvt)) == '0));

  a_r7_irq_needs_source: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ((|pendQ) && (|maskQ)));
endmodule

// File: rtl/key_edge_irq.sv
module key_edge_irq
  import keyirq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [KEY_COUNT-1:0] keyState,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [REG_W-1:0]     wrData,
  output logic [REG_W-1:0]     rdData,
  output logic                 irq
);
  regStrobe_t strobe;

  keyirq_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .addr   (addr),
    .strobe (strobe)
  );

  keyirq_datapath i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .keyState (keyState),
    .wrData   (wrData),
    .strobe   (strobe),
    .rdData   (rdData),
    .irq      (irq)
  );
endmodule

// File: tb/test_key_edge_irq.sv
module test_key_edge_irq;
  logic        clk = 1'b0;
  logic        rstN;
  logic [63:0] keys;
  logic        wrEn;
  logic [7:0]  addr;
  logic [31:0] wrData;
  logic [31:0] rdData;
  logic        irq;
  int          nChecks = 0;
  int          nFails  = 0;

  always #4 clk = ~clk;

  key_edge_irq i_key_edge_irq (
    .clk(clk), .rstN(rstN), .keyState(keys), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic readNow(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic readReg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    readNow(a, d);
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setKeys(input logic [63:0] v);
    @(negedge clk);
    keys = v;
  endtask

  task automatic clearAll();
    writeReg(8'hB8, 32'hFFFF_FFFF);
    writeReg(8'hBC, 32'hFFFF_FFFF);
  endtask

  task automatic testReset();
    logic [31:0] d;
    readReg(8'hC0, d); check("R1 pend0", d, 0);
    readReg(8'hC4, d); check("R1 pend1", d, 0);
    readReg(8'hB0, d); check("R1 mask0", d, 0);
    readReg(8'h9C, d); check("R1 mode3", d, 0);
    readReg(8'h80, d); check("R1 cfg", d, 0);
    check("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic testRising();
    logic [31:0] d;
    writeReg(8'h90, 32'h1);
    setKeys(64'h1);
    readNow(8'hC0, d); check("R11 pend before edge", d, 0);
    check("R11 irq before edge", {31'b0, irq}, 0);
    readReg(8'hC0, d); check("R2 rising key0", d, 32'h1);
    check("R11 irq after edge", {31'b0, irq}, 1);
    clearAll();
    readReg(8'hC0, d); check("R5 cleared", d, 0);
    check("R7 irq low after clear", {31'b0, irq}, 0);
    setKeys(64'h0);
    readReg(8'hC0, d); check("R2 rising ignores fall", d, 0);
  endtask

  task automatic testFalling();
    logic [31:0] d;
    writeReg(8'h94, 32'h8);
    setKeys(64'h1 << 17);
    readReg(8'hC0, d); check("R2 falling ignores rise", d, 0);
    setKeys(64'h0);
    readReg(8'hC0, d); check("R2 falling key17", d, 32'h1 << 17);
    clearAll();
  endtask

  task automatic testBoth();
    logic [31:0] d;
    writeReg(8'h9C, 32'hC000_0000);
    setKeys(64'h1 << 63);
    readReg(8'hC4, d); check("R2 both rise key63", d, 32'h8000_0000);
    clearAll();
    setKeys(64'h0);
    readReg(8'hC4, d); check("R2 both fall key63", d, 32'h8000_0000);
    clearAll();
  endtask

  task automatic testModeOff();
    logic [31:0] d;
    setKeys(64'h1 << 5);
    setKeys(64'h0);
    readReg(8'hC0, d); check("R2 mode0 no capture", d, 0);
    check("R2 mode0 irq", {31'b0, irq}, 0);
  endtask

  task automatic testMask();
    logic [31:0] d;
    writeReg(8'hB4, 32'h0);
    writeReg(8'h98, 32'h0001_0000);
    setKeys(64'h1 << 40);
    readReg(8'hC4, d); check("R3 key40 pending bit8", d, 32'h100);
    check("R7 masked irq low", {31'b0, irq}, 0);
    writeReg(8'hB4, 32'h100);
    check("R3 row5 col0 enable irq", {31'b0, irq}, 1);
    clearAll();
    check("R7 irq drops", {31'b0, irq}, 0);
    setKeys(64'h0);
  endtask

  task automatic testEnable();
    logic [31:0] d;
    writeReg(8'h80, 32'h0);
    setKeys(64'h1);
    readReg(8'hC0, d); check("R4 disabled no capture", d, 0);
    setKeys(64'h0);
    writeReg(8'h80, 32'h1);
    readReg(8'hC0, d); check("R4 still empty", d, 0);
  endtask

  task automatic testPartialClear();
    logic [31:0] d;
    writeReg(8'h90, 32'h5);
    setKeys(64'h3);
    readReg(8'hC0, d); check("R2 two keys pending", d, 32'h3);
    writeReg(8'hB8, 32'h1);
    readReg(8'hC0, d); check("R5 partial clear", d, 32'h2);
    writeReg(8'hB8, 32'hFFFF_FFFF);
    readReg(8'hC0, d); check("R5 full clear", d, 0);
    setKeys(64'h0);
  endtask

  task automatic testCollision();
    logic [31:0] d;
    setKeys(64'h3);
    setKeys(64'h0);
    readReg(8'hC0, d); check("R6 setup", d, 32'h3);
    @(negedge clk);
    keys = 64'h1; wrEn = 1'b1; addr = 8'hB8; wrData = 32'h3;
    @(negedge clk);
    wrEn = 1'b0;
    readNow(8'hC0, d); check("R6 edge wins over clear", d, 32'h1);
    clearAll();
    setKeys(64'h0);
  endtask

  task automatic testPendWrite();
    logic [31:0] d;
    setKeys(64'h1);
    writeReg(8'hC0, 32'h0);
    readReg(8'hC0, d); check("R8 write to pending ignored", d, 32'h1);
    writeReg(8'hC4, 32'hFFFF_FFFF);
    readReg(8'hC4, d); check("R8 write to pending1 ignored", d, 0);
    clearAll();
    setKeys(64'h0);
  endtask

  task automatic testStatus();
    logic [31:0] d;
    setKeys(64'h0123_4567_89AB_CDEF);
    readReg(8'hA0, d); check("R9 status low", d, 32'h89AB_CDEF);
    readReg(8'hA4, d); check("R9 status high", d, 32'h0123_4567);
    setKeys(64'h0);
    clearAll();
  endtask

  task automatic testReadback();
    logic [31:0] d;
    writeReg(8'h94, 32'hA5A5_5A5A);
    readReg(8'h94, d); check("R10 mode1 readback", d, 32'hA5A5_5A5A);
    readReg(8'hB4, d); check("R10 mask1 readback", d, 32'h100);
    readReg(8'h80, d); check("R10 cfg readback", d, 32'h1);
  endtask

  initial begin
    #(8 * 150000);
    nFails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0; keys = '0; wrEn = 1'b0; addr = '0; wrData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    writeReg(8'h80, 32'h1);
    writeReg(8'hB0, 32'hFFFF_FFFF);
    writeReg(8'hB4, 32'hFFFF_FFFF);
    testRising();
    testFalling();
    testBoth();
    testModeOff();
    testMask();
    testEnable();
    testPartialClear();
    testCollision();
    testPendWrite();
    testStatus();
    testReadback();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule